// File: doc/BRIEF.md
# SPI Burst Write Sequencer

This block is an SPI host that delivers one burst write to a target device inside a single chip-select frame. A command carries a 32-bit target address and a beat count. Each beat is sixteen payload bytes. The payload arrives on an 8-bit valid/ready stream. Within one frame the sequencer does four things in order. It programs the target's address, beat-count and byte-count registers with write pairs, each pair being a command byte (0x80 or'd with the register number) followed by a data byte. It then streams the payload bytes raw. It closes with a control write that starts the target's transfer. When the frame is over it reports the outcome on a one-cycle completion strobe.

One SPI tick equals one `clk` cycle. SCK idles low and changes level on every tick while bits are moving. MOSI carries each byte MSB first and changes only while SCK is low, so the target samples on the rising edge. Bytes follow one another with no idle tick in between. The payload stream is back-pressured through a single-byte holding buffer. `pay_ready` is high only while a frame is active, the buffer is empty and some of the frame's payload is still outstanding. A byte is taken on a cycle where `pay_valid` and `pay_ready` are both high. If the next payload byte has not arrived when it is due, the bus freezes with SCK low until it has. The command port takes a command only when the block is idle. A source may hold `cmd_valid` for as long as it likes, and the command is taken on the first cycle where `cmd_ready` is high.

Top module: `spi_burst_writer`

## Requirements
- R1: After reset, `spi_cs_n`=1, `spi_sck`=0, `spi_mosi`=0, `cmd_ready`=1, `pay_ready`=0 and `done_valid`=0.
- R2: When a command with a nonzero beat count is accepted, `spi_cs_n` goes low in the next cycle with `spi_sck` low for that tick. From then on `spi_sck` alternates high and low on every tick, except during stalls (R11). `spi_cs_n` stays low until the frame ends.
- R3: Each byte is driven MSB first. `spi_mosi` changes only in ticks where `spi_sck` is low, and it holds its value through the following high tick.
- R4: The frame opens with the address pairs 0x80,A[7:0], 0x81,A[15:8], 0x82,A[23:16], 0x83,A[31:24].
- R5: Next come the beat-count pairs 0x84,(B-1)[7:0] and 0x85,(B-1)[15:8], where B is the beat count.
- R6: Next come the byte-count pairs 0x8A,(16B-1)[7:0] and 0x8B,(16B-1)[15:8].
- R7: Next come exactly 16×B payload bytes, in stream order, with no command bytes between them.
- R8: The frame ends with 0x86, 0x02. In the tick after the last high SCK tick, `spi_cs_n`=1, `spi_sck`=0 and `spi_mosi`=0, and in that same cycle `done_valid`=1 with `done_ok`=1 for exactly one cycle.
- R9: A command with beat count 0 produces, in the next cycle, `done_valid`=1 with `done_ok`=0. The bus is not touched and no payload byte is accepted.
- R10: When the payload is always available, a frame of N bytes holds `spi_cs_n` low for exactly 16×N ticks.
- R11: If a payload byte is due but the buffer is empty, SCK and MOSI stay low with `spi_cs_n` low. The byte starts on the tick after it enters the buffer.
- R12: `pay_ready` is high only during an active frame, with the buffer empty and fewer than 16×B bytes taken. A byte moves on `pay_valid && pay_ready`.
- R13: `cmd_ready` is high only when idle. A command presented during a frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one SPI tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| cmd_addr | input | 32 | Target address of the burst |
| cmd_beats | input | BEAT_W | Number of 16-byte beats (0 is rejected) |
| pay_valid | input | 1 | Payload byte offered |
| pay_ready | output | 1 | Payload byte taken this cycle when valid |
| pay_data | input | 8 | Payload byte |
| done_valid | output | 1 | One-cycle completion strobe |
| done_ok | output | 1 | 1 = frame sent, 0 = command rejected |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to target |

## Verification
A wrong byte position or a wrong segment state shows on MOSI within at most sixteen ticks, because the next byte shifted out differs from the expected frame. A wrong bit counter or phase state breaks the strict SCK alternation or moves a MOSI change into a high tick, and this is visible on the very next clock. A wrong payload count shows as `pay_ready` staying high too long or dropping early. It also shows as a trailer arriving at the wrong time, which the per-clock comparison against the reference model catches in the cycle where it happens. A mishandled stall appears as SCK toggling while the buffer is empty.

// File: rtl/spi_bw_pkg.sv
package spi_bw_pkg;
  localparam logic [7:0] WR_BIT    = 8'h80;
  localparam logic [6:0] REG_ADDR0 = 7'h00;
  localparam logic [6:0] REG_BEAT0 = 7'h04;
  localparam logic [6:0] REG_LEN0  = 7'h0A;
  localparam logic [6:0] REG_CTRL  = 7'h06;
  localparam logic [7:0] CTRL_GO   = 8'h02;
  localparam int         HDR_BYTES = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_STALL} bit_st_e;
  typedef enum logic [1:0] {SEG_HDR, SEG_PAY, SEG_TRL} seg_e;

  function automatic logic [7:0] wr_cmd(input logic [6:0] r);
    return WR_BIT | {1'b0, r};
  endfunction
endpackage

// File: rtl/spi_bw_hdr_gen.sv
// Produces header byte idx (0..15) of the register-programming preamble.
// BEAT_W must not exceed 12 so the byte count fits its 16-bit field.
module spi_bw_hdr_gen import spi_bw_pkg::*; #(
  parameter int BEAT_W = 12
) (
  input  logic [3:0]        idx,
  input  logic [31:0]       addr,
  input  logic [BEAT_W-1:0] beats_m1,
  output logic [7:0]        byte_o
);
  logic [2:0]  pair;
  logic [15:0] beat_f;
  logic [15:0] len_f;

  always_comb begin
    pair   = idx[3:1];
    beat_f = 16'(beats_m1);
    len_f  = 16'({beats_m1, 4'hF});
    byte_o = 8'h00;
    if (!idx[0]) begin
      case (pair)
        3'd0, 3'd1, 3'd2, 3'd3: byte_o = wr_cmd(REG_ADDR0 + {5'b0, pair[1:0]});
        3'd4, 3'd5:             byte_o = wr_cmd(REG_BEAT0 + {6'b0, pair[0]});
        default:                byte_o = wr_cmd(REG_LEN0  + {6'b0, pair[0]});
      endcase
    end else begin
      case (pair)
        3'd0, 3'd1, 3'd2, 3'd3: byte_o = addr[{pair[1:0], 3'b000} +: 8];
        3'd4:                   byte_o = beat_f[7:0];
        3'd5:                   byte_o = beat_f[15:8];
        3'd6:                   byte_o = len_f[7:0];
        default:                byte_o = len_f[15:8];
      endcase
    end
  end
endmodule

// File: rtl/spi_bw_paybuf.sv
// One-byte holding buffer with a per-frame fetch budget.
module spi_bw_paybuf #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] total,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             pop,
  output logic             full,
  output logic [7:0]       data
);
  logic             full_q;
  logic [7:0]       data_q;
  logic [CNT_W-1:0] left_q;
  logic             fire;

  assign in_ready = !full_q && (left_q != '0);
  assign fire     = in_valid && in_ready;
  assign full     = full_q;
  assign data     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= 8'h00;
      left_q <= '0;
    end else begin
      if (start)     left_q <= total;
      else if (fire) left_q <= left_q - 1'b1;
      if (fire) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end else if (pop) begin
        full_q <= 1'b0;
      end
    end
  end

  assert_pop_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> full_q) else $error("pop from empty payload buffer");

  assert_start_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!full_q && left_q == '0)) else $error("frame started with stale payload state");
endmodule

// File: rtl/spi_burst_writer.sv
module spi_burst_writer import spi_bw_pkg::*; #(
  parameter int BEAT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [31:0]       cmd_addr,
  input  logic [BEAT_W-1:0] cmd_beats,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [7:0]        pay_data,
  output logic              done_valid,
  output logic              done_ok,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi
);
  localparam int              LEN_W    = BEAT_W + 4;
  localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(HDR_BYTES - 1);

  bit_st_e           st;
  seg_e              seg, nseg;
  logic [LEN_W-1:0]  cnt, ncnt, len_m1;
  logic [2:0]        bit_idx;
  logic [7:0]        shreg, hdr_byte, next_byte;
  logic [31:0]       addr_q;
  logic [BEAT_W-1:0] beats_m1_q;
  logic              done_v_q, done_ok_q;
  logic              cmd_fire, start_frame, frame_end, byte_done;
  logic              buf_full, buf_pop;
  logic [7:0]        buf_data;

  assign cmd_ready   = (st == ST_IDLE);
  assign cmd_fire    = cmd_valid && cmd_ready;
  assign start_frame = cmd_fire && (cmd_beats != '0);
  assign len_m1      = {beats_m1_q, 4'hF};
  assign byte_done   = (st == ST_HIGH) && (bit_idx == 3'd0);

  // Position of the byte following the one now on the wire.
  always_comb begin
    nseg      = seg;
    ncnt      = cnt + 1'b1;
    frame_end = 1'b0;
    case (seg)
      SEG_HDR: if (cnt == HDR_LAST) begin nseg = SEG_PAY; ncnt = '0; end
      SEG_PAY: if (cnt == len_m1)   begin nseg = SEG_TRL; ncnt = '0; end
      default: if (cnt != '0)       frame_end = 1'b1;
    endcase
  end

  spi_bw_hdr_gen #(.BEAT_W(BEAT_W)) u_hdr (
    .idx      (ncnt[3:0]),
    .addr     (addr_q),
    .beats_m1 (beats_m1_q),
    .byte_o   (hdr_byte)
  );

  always_comb begin
    if (nseg == SEG_HDR)   next_byte = hdr_byte;
    else if (ncnt == '0)   next_byte = wr_cmd(REG_CTRL);
    else                   next_byte = CTRL_GO;
  end

  assign buf_pop = (byte_done && !frame_end && nseg == SEG_PAY && buf_full) ||
                   (st == ST_STALL && buf_full);

  spi_bw_paybuf #(.CNT_W(LEN_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_frame),
    .total    ({cmd_beats, 4'h0}),
    .in_valid (pay_valid),
    .in_ready (pay_ready),
    .in_data  (pay_data),
    .pop      (buf_pop),
    .full     (buf_full),
    .data     (buf_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      seg        <= SEG_HDR;
      cnt        <= '0;
      bit_idx    <= 3'd0;
      shreg      <= 8'h00;
      addr_q     <= 32'h0;
      beats_m1_q <= '0;
      done_v_q   <= 1'b0;
      done_ok_q  <= 1'b0;
    end else begin
      done_v_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_fire) begin
            if (cmd_beats == '0) begin
              done_v_q  <= 1'b1;
              done_ok_q <= 1'b0;
            end else begin
              addr_q     <= cmd_addr;
              beats_m1_q <= cmd_beats - 1'b1;
              seg        <= SEG_HDR;
              cnt        <= '0;
              shreg      <= wr_cmd(REG_ADDR0);
              bit_idx    <= 3'd7;
              st         <= ST_LOW;
            end
          end
        end
        ST_LOW: st <= ST_HIGH;
        ST_HIGH: begin
          if (bit_idx != 3'd0) begin
            shreg   <= {shreg[6:0], 1'b0};
            bit_idx <= bit_idx - 1'b1;
            st      <= ST_LOW;
          end else if (frame_end) begin
            st        <= ST_IDLE;
            done_v_q  <= 1'b1;
            done_ok_q <= 1'b1;
          end else begin
            seg <= nseg;
            cnt <= ncnt;
            if (nseg == SEG_PAY) begin
              if (buf_full) begin
                shreg   <= buf_data;
                bit_idx <= 3'd7;
                st      <= ST_LOW;
              end else begin
                st <= ST_STALL;
              end
            end else begin
              shreg   <= next_byte;
              bit_idx <= 3'd7;
              st      <= ST_LOW;
            end
          end
        end
        default: begin
          if (buf_full) begin
            shreg   <= buf_data;
            bit_idx <= 3'd7;
            st      <= ST_LOW;
          end
        end
      endcase
    end
  end

  assign spi_sck    = (st == ST_HIGH);
  assign spi_cs_n   = (st == ST_IDLE);
  assign spi_mosi   = ((st == ST_LOW) || (st == ST_HIGH)) && shreg[7];
  assign done_valid = done_v_q;
  assign done_ok    = done_ok_q;

  assert_sck_framed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n) else $error("SCK high outside frame");

  assert_sck_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |=> !spi_sck) else $error("SCK high for two ticks");

  assert_mosi_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi)) else $error("MOSI changed with SCK rise");

  assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd_beats == '0) |=> (done_valid && !done_ok && spi_cs_n))
    else $error("zero-beat command not rejected");

  assert_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_ok) |-> (spi_cs_n && !spi_sck && !spi_mosi && $past(spi_sck)))
    else $error("bad frame close");
endmodule

// File: tb/tb_spi_burst_writer.sv
module tb_spi_burst_writer;
  localparam int BEAT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [31:0] cmd_addr = 32'h0;
  logic [BEAT_W-1:0] cmd_beats = '0;
  logic pay_valid = 1'b0;
  logic [7:0] pay_data = 8'h00;
  logic cmd_ready, pay_ready, done_valid, done_ok, spi_sck, spi_cs_n, spi_mosi;

  int checks = 0;
  int errors = 0;

  spi_burst_writer #(.BEAT_W(BEAT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_beats(cmd_beats),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .done_valid(done_valid), .done_ok(done_ok),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Stimulus payload and gating
  int pay_q[$];
  int gate_mode = 0;
  int hold_cnt = 0;

  // Reference model state
  int  m_st = 0;
  int  m_frame[$];
  int  m_byte = 0;
  int  m_bit = 0;
  bit  m_full = 0;
  int  m_bufv = 0;
  int  m_fetch = 0;
  bit  m_dv = 0;
  bit  m_dok = 0;
  bit  m_pr = 0;
  bit  m_fire = 0;
  int  m_fdat = 0;
  bit  m_live = 0;

  int hdr_tmp[16];

  function automatic void fill_hdr(input int unsigned addr, input int beats);
    int bm = beats - 1;
    int lm = beats * 16 - 1;
    for (int k = 0; k < 4; k++) begin
      hdr_tmp[2*k]   = 'h80 + k;
      hdr_tmp[2*k+1] = (addr >> (8*k)) & 'hFF;
    end
    hdr_tmp[8]  = 'h84; hdr_tmp[9]  = bm & 'hFF;
    hdr_tmp[10] = 'h85; hdr_tmp[11] = (bm >> 8) & 'hFF;
    hdr_tmp[12] = 'h8A; hdr_tmp[13] = lm & 'hFF;
    hdr_tmp[14] = 'h8B; hdr_tmp[15] = (lm >> 8) & 'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_full = 0; m_fetch = 0; m_dv = 0; m_dok = 0; m_frame.delete();
    end else begin
      m_pr   = (m_st != 0) && !m_full && (m_fetch > 0);
      m_fire = pay_valid && m_pr;
      m_fdat = int'(pay_data);
      m_dv   = 0;
      case (m_st)
        0: if (cmd_valid) begin
          if (cmd_beats == 0) begin
            m_dv = 1; m_dok = 0;
          end else begin
            fill_hdr(cmd_addr, int'(cmd_beats));
            m_frame.delete();
            for (int k = 0; k < 16; k++) m_frame.push_back(hdr_tmp[k]);
            for (int k = 0; k < 16*int'(cmd_beats); k++) m_frame.push_back(256);
            m_frame.push_back('h86);
            m_frame.push_back('h02);
            m_byte = m_frame.pop_front();
            m_bit = 7; m_st = 1;
            m_fetch = 16*int'(cmd_beats);
          end
        end
        1: m_st = 2;
        2: begin
          if (m_bit > 0) begin
            m_bit--; m_st = 1;
          end else if (m_frame.size() == 0) begin
            m_st = 0; m_dv = 1; m_dok = 1;
          end else if (m_frame[0] == 256) begin
            if (m_full) begin
              void'(m_frame.pop_front());
              m_byte = m_bufv; m_full = 0; m_bit = 7; m_st = 1;
            end else m_st = 3;
          end else begin
            m_byte = m_frame.pop_front(); m_bit = 7; m_st = 1;
          end
        end
        default: if (m_full) begin
          void'(m_frame.pop_front());
          m_byte = m_bufv; m_full = 0; m_bit = 7; m_st = 1;
        end
      endcase
      if (m_fire) begin
        m_full = 1; m_bufv = m_fdat; m_fetch--;
        void'(pay_q.pop_front());
      end
    end
  end

  // Capture, per-clock comparison, and payload driving
  int  cap_q[$];
  int  cap_byte = 0;
  int  cap_bits = 0;
  bit  prev_sck = 0;
  int  lowcnt = 0;

  always @(negedge clk) begin
    if (rst_n && m_live) begin
      chk(spi_cs_n == (m_st == 0), "R2 cs_n", spi_cs_n, m_st == 0);
      chk(spi_sck == (m_st == 2), "R2 sck", spi_sck, m_st == 2);
      chk(spi_mosi == ((m_st == 1 || m_st == 2) ? ((m_byte >> m_bit) & 1) : 0), "R3 mosi",
          spi_mosi, (m_st == 1 || m_st == 2) ? ((m_byte >> m_bit) & 1) : 0);
      chk(cmd_ready == (m_st == 0), "R13 cmd_ready", cmd_ready, m_st == 0);
      chk(pay_ready == ((m_st != 0) && !m_full && (m_fetch > 0)), "R12 pay_ready", pay_ready,
          (m_st != 0) && !m_full && (m_fetch > 0));
      chk(done_valid == m_dv, "R8 done_valid", done_valid, m_dv);
      if (m_dv) chk(done_ok == m_dok, "R8 done_ok", done_ok, m_dok);
      if (spi_sck && !prev_sck) begin
        cap_byte = ((cap_byte << 1) | int'(spi_mosi)) & 'hFF;
        cap_bits++;
        if (cap_bits == 8) begin cap_q.push_back(cap_byte); cap_bits = 0; end
      end
      if (!spi_cs_n) lowcnt++;
    end
    prev_sck = spi_sck;
    if (hold_cnt > 0) hold_cnt--;
    pay_valid = (pay_q.size() > 0) &&
                ((gate_mode == 0) || (gate_mode == 1 && ($urandom % 2) == 1) ||
                 (gate_mode == 2 && hold_cnt == 0));
    pay_data = (pay_q.size() > 0) ? 8'(pay_q[0]) : 8'h00;
  end

  task automatic send_cmd(input logic [31:0] a, input int b);
    @(negedge clk);
    cmd_addr = a; cmd_beats = BEAT_W'(b); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 120000; i++) begin
      @(negedge clk);
      if (done_valid) begin seen = 1; break; end
    end
  endtask

  // Runs one frame and checks its byte content against the requirements.
  task automatic run_frame(input logic [31:0] a, input int b, input int mode, input int hold,
                           input int seed, input bit poke_cmd, output int ticks);
    int exp[$];
    bit seen;
    fill_hdr(a, b);
    pay_q.delete();
    cap_q.delete(); cap_bits = 0;
    for (int k = 0; k < 16*b; k++) pay_q.push_back((k*37 + seed) & 'hFF);
    for (int k = 0; k < 16; k++) exp.push_back(hdr_tmp[k]);
    foreach (pay_q[k]) exp.push_back(pay_q[k]);
    exp.push_back('h86); exp.push_back('h02);
    gate_mode = mode; hold_cnt = hold;
    lowcnt = 0;
    send_cmd(a, b);
    if (poke_cmd) begin
      repeat (40) @(negedge clk);
      cmd_beats = BEAT_W'(5); cmd_valid = 1'b1;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
    end
    wait_done(seen);
    chk(seen, "R8 completion seen", seen, 1);
    chk(done_ok == 1'b1, "R8 done_ok", done_ok, 1);
    chk(spi_cs_n && !spi_sck && !spi_mosi, "R8 idle levels at done",
        {spi_cs_n, spi_sck, spi_mosi}, 3'b100);
    ticks = lowcnt;
    chk(cap_q.size() == exp.size(), "R7 frame length", cap_q.size(), exp.size());
    for (int k = 0; k < exp.size() && k < cap_q.size(); k++) begin
      if (k < 8)        chk(cap_q[k] == exp[k], "R4 address pair byte", cap_q[k], exp[k]);
      else if (k < 12)  chk(cap_q[k] == exp[k], "R5 beat pair byte", cap_q[k], exp[k]);
      else if (k < 16)  chk(cap_q[k] == exp[k], "R6 length pair byte", cap_q[k], exp[k]);
      else if (k < exp.size() - 2) chk(cap_q[k] == exp[k], "R7 payload byte", cap_q[k], exp[k]);
      else              chk(cap_q[k] == exp[k], "R8 trailer byte", cap_q[k], exp[k]);
    end
    chk(pay_q.size() == 0, "R12 payload fully taken", pay_q.size(), 0);
  endtask

  initial begin
    int t;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_live = 1;
    @(negedge clk);
    chk(spi_cs_n && !spi_sck && !spi_mosi, "R1 bus idle", {spi_cs_n, spi_sck, spi_mosi}, 3'b100);
    chk(cmd_ready && !pay_ready && !done_valid, "R1 handshake idle",
        {cmd_ready, pay_ready, done_valid}, 3'b100);

    // R9: zero beats rejected; an offered payload byte stays untaken
    pay_q.push_back('h5A); gate_mode = 0;
    lowcnt = 0;
    send_cmd(32'hDEAD_BEEF, 0);
    chk(done_valid && !done_ok, "R9 reject strobe", {done_valid, done_ok}, 2'b10);
    chk(spi_cs_n == 1'b1, "R9 no frame", spi_cs_n, 1);
    repeat (20) @(negedge clk);
    chk(lowcnt == 0, "R9 bus untouched", lowcnt, 0);
    chk(pay_q.size() == 1, "R9 payload not taken", pay_q.size(), 1);
    pay_q.delete();
    @(negedge clk);

    // R10, R13: one beat, payload always present, command poked mid-frame
    run_frame(32'h1234_5678, 1, 0, 0, 3, 1'b1, t);
    chk(t == 16*(18+16), "R10 no gaps", t, 16*(18+16));
    lowcnt = 0;
    repeat (20) @(negedge clk);
    chk(lowcnt == 0, "R13 ignored command starts no frame", lowcnt, 0);

    // R11: random payload gaps
    run_frame(32'hA5C3_0F01, 2, 1, 0, 91, 1'b0, t);
    chk(t >= 16*(18+32), "R11 frame length with gaps", t, 16*(18+32));

    // R11: long initial hold forces a stall at the first payload byte
    run_frame(32'h0000_00FF, 3, 2, 400, 200, 1'b0, t);
    chk(t > 16*(18+48), "R11 stall lengthens frame", t, 16*(18+48));

    // R5, R6: beat count with nonzero high bytes
    run_frame(32'hFEDC_BA98, 'h101, 0, 0, 7, 1'b0, t);
    chk(t == 16*(18+16*'h101), "R10 long frame no gaps", t, 16*(18+16*'h101));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule